// File: doc/BRIEF.md
# Lap Stopwatch with Best-Time Record

This block is a synchronous stopwatch for timing laps. It counts elapsed time in 10 ms steps, driven by a tick enable that is generated outside the block. The time is kept twice and in lockstep: as four BCD digits (hundredths, tenths, seconds, tens of seconds) and as a 16-bit binary tick count. Four one-cycle key strobes steer a small state machine. The keys are start, stop, store and clear.

The block also keeps a best-time record. The record starts at 99.99 s. A store key replaces the record with the current time only when the current time is strictly smaller. A display-select flag chooses what the digit output shows: the running time, or the BCD digits of the record. The FSM state drives three flags: count enable, record written, and display select. The keys arrive debounced, one clock cycle wide, and the digit output goes to a seven-segment encoder outside the block.

Top module: `lap_timer_best`

## Requirements
- R1: After synchronous reset the flags {runEn,recWr,showRec} are 000, tickCount is 0, bestTime is 9999 and dispDigits is 0000.
- R2: Keys are served in the order start, stop, store, clear. A lower key pressed in the same cycle as a higher one is ignored. With no key pressed, the state is held.
- R3: The flags {runEn,recWr,showRec} are 000 in idle, 100 in timing, 000 in pause, 011 in update, 001 in keep and 010 in cleared.
- R4: In timing, each cycle with tick high adds one to tickCount. The same tick advances the BCD digits with a decimal carry. dispDigits holds the 10 ms digit in bits [3:0], the 100 ms digit in [7:4], the seconds digit in [11:8] and the tens of seconds digit in [15:12].
- R5: A counted tick at 99.99 takes tickCount and the digits to 0 / 00.00, and counting continues.
- R6: An accepted start clears the time to 0 and enters timing. An accepted clear sets the time to 0, sets the record to 9999 and stops the count.
- R7: An accepted store writes tickCount into bestTime only when tickCount < bestTime. An equal or larger time leaves the record unchanged. The write happens on the same edge at which the state enters update (written) or keep (not written).
- R8: dispDigits shows the time digits when showRec is 0. When showRec is 1 it shows the BCD digits of bestTime.
- R9: Ticks outside the timing state leave tickCount and the digits unchanged.
- R10: A store accepted in timing in the same cycle as a tick records the count from before that tick. The tick is still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 10 ms count enable |
| keyStart | input | 1 | Start key strobe |
| keyStop | input | 1 | Stop key strobe |
| keyStore | input | 1 | Store key strobe |
| keyClear | input | 1 | Clear key strobe |
| runEn | output | 1 | Count enable flag (timing state) |
| recWr | output | 1 | Record written flag |
| showRec | output | 1 | Display select: 1 shows the record |
| tickCount | output | 16 | Binary count of 10 ms ticks |
| bestTime | output | 16 | Best recorded time in ticks |
| dispDigits | output | 16 | Four BCD digits of the selected value |

## Verification
Two functions can coincide in one cycle: a store key can arrive while the counter is running and a tick is being counted. The bench provokes this by raising tick together with store while timing at a count of 5. It then expects the record to hold 5, the count to read 6, and the state to be update, so that the following ticks are not counted. A second collision is tested by pressing keys in pairs: a start arriving with any other key, a stop together with store, and store together with clear. Each pair is judged against the fixed key priority by reading the flags and the record afterwards.

// File: rtl/lap_timer_pkg.sv
package lap_timer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_HOLD    = 3'd2,
    ST_NEWBEST = 3'd3,
    ST_KEEP    = 3'd4,
    ST_CLEARED = 3'd5
  } lapState_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clrTime;   // zero the time counters
    logic cntEn;     // advance time by one tick
    logic wrBest;    // copy current time into the record
    logic initBest;  // reload the record with its maximum
  } dpCmd_t;

endpackage

// File: rtl/lap_timer_ctrl.sv
module lap_timer_ctrl
  import lap_timer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   keyStart,
  input  logic   keyStop,
  input  logic   keyStore,
  input  logic   keyClear,
  input  logic   isFaster,
  output dpCmd_t cmd,
  output logic   runEn,
  output logic   recWr,
  output logic   showRec
);

  lapState_e stateQ, stateNxt;
  logic takeStore, takeClear;

  assign takeStore = keyStore & ~keyStart & ~keyStop;
  assign takeClear = keyClear & ~keyStart & ~keyStop & ~keyStore;

  always_comb begin
    stateNxt = stateQ;
    if (keyStart)      stateNxt = ST_RUN;
    else if (keyStop)  stateNxt = ST_HOLD;
    else if (takeStore) stateNxt = isFaster ? ST_NEWBEST : ST_KEEP;
    else if (takeClear) stateNxt = ST_CLEARED;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNxt;
  end

  always_comb begin
    cmd.clrTime  = keyStart | takeClear;
    cmd.cntEn    = (stateQ == ST_RUN) & tick & ~cmd.clrTime;
    cmd.wrBest   = takeStore & isFaster;
    cmd.initBest = takeClear;
  end

  always_comb begin
    runEn = 1'b0; recWr = 1'b0; showRec = 1'b0;
    unique case (stateQ)
      ST_RUN:     runEn = 1'b1;
      ST_NEWBEST: begin recWr = 1'b1; showRec = 1'b1; end
      ST_KEEP:    showRec = 1'b1;
      ST_CLEARED: recWr = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/lap_timer_dp.sv
module lap_timer_dp
  import lap_timer_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpCmd_t                cmd,
  input  logic                  showRec,
  output logic                  isFaster,
  output logic [CNT_W-1:0]      tickCount,
  output logic [CNT_W-1:0]      bestTime,
  output logic [DIGITS*4-1:0]   dispDigits
);

  localparam int BCD_W = DIGITS * 4;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(10 ** DIGITS - 1);
  localparam logic [BCD_W-1:0] MAX_BCD = {DIGITS{4'd9}};

  logic [BCD_W-1:0] timeBcd;
  logic [BCD_W-1:0] bestBcd;
  logic [DIGITS:0]  carry;

  assign carry[0] = cmd.cntEn;

  // cascaded decimal digits, each advanced by a combinational carry enable
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] digQ;
    assign carry[i+1] = carry[i] & (digQ == 4'd9);
    always_ff @(posedge clk) begin
      if (rst || cmd.clrTime)  digQ <= 4'd0;
      else if (carry[i])       digQ <= (digQ == 4'd9) ? 4'd0 : digQ + 4'd1;
    end
    assign timeBcd[4*i +: 4] = digQ;
  end

  // binary tick count in lockstep with the digits
  always_ff @(posedge clk) begin
    if (rst || cmd.clrTime) tickCount <= '0;
    else if (cmd.cntEn)     tickCount <= (tickCount == MAX_CNT) ? '0 : tickCount + 1'b1;
  end

  assign isFaster = tickCount < bestTime;

  // record with its BCD image captured from the time digits
  always_ff @(posedge clk) begin
    if (rst || cmd.initBest) begin
      bestTime <= MAX_CNT;
      bestBcd  <= MAX_BCD;
    end else if (cmd.wrBest) begin
      bestTime <= tickCount;
      bestBcd  <= timeBcd;
    end
  end

  assign dispDigits = showRec ? bestBcd : timeBcd;

endmodule

// File: rtl/lap_timer_best.sv
module lap_timer_best
  import lap_timer_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                keyStart,
  input  logic                keyStop,
  input  logic                keyStore,
  input  logic                keyClear,
  output logic                runEn,
  output logic                recWr,
  output logic                showRec,
  output logic [CNT_W-1:0]    tickCount,
  output logic [CNT_W-1:0]    bestTime,
  output logic [DIGITS*4-1:0] dispDigits
);

  dpCmd_t cmd;
  logic   isFaster;

  lap_timer_ctrl ctrl_i (
    .clk(clk), .rst(rst), .tick(tick),
    .keyStart(keyStart), .keyStop(keyStop), .keyStore(keyStore), .keyClear(keyClear),
    .isFaster(isFaster), .cmd(cmd),
    .runEn(runEn), .recWr(recWr), .showRec(showRec)
  );

  lap_timer_dp #(.DIGITS(DIGITS), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst(rst), .cmd(cmd), .showRec(showRec),
    .isFaster(isFaster), .tickCount(tickCount), .bestTime(bestTime),
    .dispDigits(dispDigits)
  );

endmodule

// File: rtl/lap_timer_chk.sv
module lap_timer_chk #(
  parameter int DIGITS = 4,
  parameter int CNT_W  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                keyStart,
  input logic                keyStop,
  input logic                keyStore,
  input logic                keyClear,
  input logic                runEn,
  input logic                recWr,
  input logic                showRec,
  input logic [CNT_W-1:0]    tickCount,
  input logic [CNT_W-1:0]    bestTime,
  input logic [DIGITS*4-1:0] dispDigits
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(10 ** DIGITS - 1);

  function automatic int bcdValue(input logic [DIGITS*4-1:0] b);
    int v = 0;
    for (int i = DIGITS - 1; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
    return v;
  endfunction

  logic noReset;
  assign noReset = ~keyStart & ~keyClear;

  AST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    runEn |-> (!recWr && !showRec)); // R3

  AST_TICK_INC: assert property (@(posedge clk) disable iff (rst)
    (runEn && tick && noReset && tickCount != TOP) |=> tickCount == $past(tickCount) + 1'b1); // R4

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
    (runEn && tick && noReset && tickCount == TOP) |=> tickCount == '0); // R5

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!runEn && noReset) |=> $stable(tickCount)); // R9

  AST_STORE_FASTER: assert property (@(posedge clk) disable iff (rst)
    (keyStore && !keyStart && !keyStop && tickCount < bestTime) |=> bestTime == $past(tickCount)); // R7

  AST_BEST_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    !(keyClear && !keyStart && !keyStop && !keyStore) |=> bestTime <= $past(bestTime)); // R7

  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (keyClear && !keyStart && !keyStop && !keyStore) |=> (bestTime == TOP && tickCount == '0 && !runEn)); // R6

  AST_DISP_TIME: assert property (@(posedge clk) disable iff (rst)
    !showRec |-> bcdValue(dispDigits) == int'(tickCount)); // R8

  AST_DISP_BEST: assert property (@(posedge clk) disable iff (rst)
    showRec |-> bcdValue(dispDigits) == int'(bestTime)); // R8

endmodule

bind lap_timer_best lap_timer_chk #(.DIGITS(DIGITS), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/lap_timer_best_tb.sv
module lap_timer_best_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic keyStart = 1'b0, keyStop = 1'b0, keyStore = 1'b0, keyClear = 1'b0;
  logic runEn, recWr, showRec;
  logic [15:0] tickCount, bestTime, dispDigits;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;  // 125 MHz

  lap_timer_best dut_i (
    .clk(clk), .rst(rst), .tick(tick),
    .keyStart(keyStart), .keyStop(keyStop), .keyStore(keyStore), .keyClear(keyClear),
    .runEn(runEn), .recWr(recWr), .showRec(showRec),
    .tickCount(tickCount), .bestTime(bestTime), .dispDigits(dispDigits)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkFlags(input string req, input logic [2:0] exp);
    check(req, "flags", int'({runEn, recWr, showRec}), int'(exp));
  endtask

  // one-cycle key pulse (optionally with tick); outputs are settled on return
  task automatic press(input logic s, input logic p, input logic st, input logic c, input logic t);
    @(negedge clk);
    keyStart = s; keyStop = p; keyStore = st; keyClear = c; tick = t;
    @(negedge clk);
    keyStart = 0; keyStop = 0; keyStore = 0; keyClear = 0; tick = 0;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tResetState();
    checkFlags("R1", 3'b000);
    check("R1", "tickCount", int'(tickCount), 0);
    check("R1", "bestTime", int'(bestTime), 9999);
    check("R1", "dispDigits", int'(dispDigits), 'h0000);
  endtask

  task automatic tRunStop();
    press(1, 0, 0, 0, 0);
    checkFlags("R3", 3'b100);
    runTicks(123);
    check("R4", "tickCount", int'(tickCount), 123);
    check("R8", "dispDigits", int'(dispDigits), 'h0123);
    idle(3);
    checkFlags("R2", 3'b100);
    check("R2", "tickCount held", int'(tickCount), 123);
    press(0, 1, 0, 0, 0);
    checkFlags("R3", 3'b000);
    runTicks(5);
    check("R9", "tickCount paused", int'(tickCount), 123);
  endtask

  task automatic tStoreBetter();
    press(0, 0, 1, 0, 0);
    checkFlags("R3", 3'b011);
    check("R7", "bestTime", int'(bestTime), 123);
    check("R8", "dispDigits", int'(dispDigits), 'h0123);
  endtask

  task automatic tStoreWorse();
    press(1, 0, 0, 0, 0);
    check("R6", "tickCount restart", int'(tickCount), 0);
    runTicks(200);
    press(0, 1, 0, 0, 0);
    press(0, 0, 1, 0, 0);
    checkFlags("R3", 3'b001);
    check("R7", "bestTime worse", int'(bestTime), 123);
    check("R8", "dispDigits record", int'(dispDigits), 'h0123);
    check("R9", "tickCount", int'(tickCount), 200);
  endtask

  task automatic tStoreEqual();
    press(1, 0, 0, 0, 0);
    runTicks(123);
    press(0, 1, 0, 0, 0);
    press(0, 0, 1, 0, 0);
    checkFlags("R7", 3'b001);
    check("R7", "bestTime equal", int'(bestTime), 123);
  endtask

  task automatic tPriority();
    press(1, 1, 1, 1, 0);
    checkFlags("R2", 3'b100);
    check("R2", "best after start+all", int'(bestTime), 123);
    runTicks(10);
    check("R4", "tickCount", int'(tickCount), 10);
    press(0, 1, 1, 0, 0);
    checkFlags("R2", 3'b000);
    check("R2", "best after stop+store", int'(bestTime), 123);
    press(0, 0, 1, 1, 0);
    checkFlags("R2", 3'b011);
    check("R2", "best after store+clear", int'(bestTime), 10);
  endtask

  task automatic tClear();
    press(1, 0, 0, 0, 0);
    runTicks(7);
    press(0, 0, 0, 1, 0);
    checkFlags("R3", 3'b010);
    check("R6", "bestTime", int'(bestTime), 9999);
    check("R6", "tickCount", int'(tickCount), 0);
    runTicks(4);
    check("R6", "tickCount stopped", int'(tickCount), 0);
  endtask

  task automatic tWrap();
    press(1, 0, 0, 0, 0);
    runTicks(9999);
    check("R5", "tickCount top", int'(tickCount), 9999);
    check("R4", "dispDigits top", int'(dispDigits), 'h9999);
    runTicks(1);
    check("R5", "tickCount wrapped", int'(tickCount), 0);
    check("R5", "dispDigits wrapped", int'(dispDigits), 'h0000);
    runTicks(3);
    check("R5", "counting continues", int'(tickCount), 3);
  endtask

  task automatic tSameCycle();
    press(0, 0, 0, 1, 0);
    press(1, 0, 0, 0, 0);
    runTicks(5);
    press(0, 0, 1, 0, 1);
    checkFlags("R10", 3'b011);
    check("R10", "bestTime pre-tick", int'(bestTime), 5);
    check("R10", "tickCount counted", int'(tickCount), 6);
    runTicks(2);
    check("R10", "tickCount after", int'(tickCount), 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tResetState();
    tRunStop();
    tStoreBetter();
    tStoreWorse();
    tStoreEqual();
    tPriority();
    tClear();
    tWrap();
    tSameCycle();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule